// File: doc/BRIEF.md
# Asynchronous Serial Receive Port with Sticky Frame-Error Flag

This block is the receive half of a classic microcontroller serial port, together with the 8-bit control and status register that software uses to drive it. It watches one serial input line and works in three asynchronous formats: 8 data bits at a variable rate, and 8 data bits plus a ninth bit at either a fixed rate or a variable rate. Each bit period is 16 rate ticks long, and each bit is decided by a majority vote of three samples near the middle of the period. Completed bytes go into a receive buffer. The ninth bit, or the stop bit in the 8-bit format, is captured in a status bit.

A bad stop bit sets a sticky frame-error flag. That flag shares the top register bit with a mode bit, and an external select input chooses which of the two the CPU reads and writes through that bit. The receive-complete flag can be held back by a multiprocessor filter. This filter accepts only a frame whose byte matches a masked own address or the derived broadcast address. In the 9-bit formats the ninth bit must also be 1, and in the 8-bit format the stop bit must be valid.

The variable-rate tick is an input supplied by an external rate generator. The fixed-rate tick is made inside the block by dividing the clock.

The receive state machine has five states:
- `S_IDLE` waits for a falling edge while reception is enabled. The transition idle→start is taken on a falling edge with REN set and a UART mode selected.
- `S_START` checks the start bit at mid-bit. The transition start→idle is taken when the start bit votes high (a glitch). The transition start→data is taken when it votes low.
- `S_DATA` shifts in the data bits, least significant bit first. After the last data bit, the transition data→ninth is taken in a 9-bit mode and data→stop in the 8-bit mode.
- `S_NINTH` captures the ninth bit. The transition ninth→stop follows it.
- `S_STOP` samples the stop bit at mid-bit and issues a one-cycle completion. The transition stop→idle follows.

Top module: `srx_port`

## Requirements
- R1: After reset, the register reads 0x00 with either select value, and the receive buffer reads 0x00.
- R2: The register layout is: bit 7 mode bit A or frame-error flag, bit 6 mode bit B, bit 5 filter enable, bit 4 receive enable (REN), bit 3 transmit ninth bit, bit 2 received ninth bit, bit 1 transmit flag (TI), bit 0 receive flag (RI). With `sel_fe`=1, reads and writes of bit 7 reach the frame-error flag. With `sel_fe`=0 they reach mode bit A. The bit that is not selected keeps its value.
- R3: A stop bit that votes 0 sets the frame-error flag. This happens even when the address filter discards the frame. A later valid frame leaves the flag set. Only a CPU write of 0 to bit 7 with `sel_fe`=1 clears it.
- R4: The mode is {A,B}: 00 shift mode, 01 8-bit variable rate, 10 9-bit fixed rate, 11 9-bit variable rate. A falling edge on `rxd` is ignored while REN is 0 or while the mode is 00.
- R5: With the filter off in mode 01, every frame sets RI, loads the receive buffer, and copies the stop bit into bit 2.
- R6: In modes 10 and 11, the ninth received bit is copied into bit 2 when the frame is accepted.
- R7: In modes 10 and 11 with the filter on, RI is set only if the ninth bit is 1 and the byte hits an address.
- R8: In mode 01 with the filter on, RI is set only if the stop bit is 1 and the byte hits an address.
- R9: A byte hits the own address when (byte AND `addr_mask`) equals (`own_addr` AND `addr_mask`). It hits the broadcast address when every bit set in (`own_addr` OR `addr_mask`) is also set in the byte.
- R10: The receive buffer and bit 2 change only on a frame that sets RI. RI and TI fall only through CPU writes. Bits 3 and 1 hold whatever the CPU wrote.
- R11: Modes 01 and 11 count 16 `var_tick` pulses per bit. Mode 10 makes its own tick every 4 clocks (64 clocks per bit), or every 2 clocks (32 clocks per bit) when `fix_dbl`=1.
- R12: Each bit is the majority of three samples taken at ticks 7, 8 and 9 after the edge. A start bit that votes high is dropped, and the receiver returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial input line, idle high |
| var_tick | input | 1 | Variable-rate tick, 16 per bit |
| fix_dbl | input | 1 | Doubles the fixed rate in mode 10 |
| sel_fe | input | 1 | 1: bit 7 is the frame-error flag; 0: bit 7 is mode bit A |
| own_addr | input | 8 | Own address for the filter |
| addr_mask | input | 8 | Address mask for the filter |
| reg_wr | input | 1 | CPU write strobe for the register |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | Register read value |
| rx_buf | output | 8 | Receive buffer |

## Verification
The bench builds the block with its defaults: 8 data bits, 16 ticks per bit and a fixed-rate divide of 4. It toggles `var_tick` every other clock, which gives 32-clock bits in the variable modes. With these values, both fixed-rate speeds (32 and 64 clocks per bit) and the variable rate can be reached within a few thousand cycles each. The own address 0x40 and the mask 0xF0 make the masked own-address hit, the broadcast hit on 0xF_ bytes and a miss all reachable with single frames.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_START = 3'd1,
        S_DATA  = 3'd2,
        S_NINTH = 3'd3,
        S_STOP  = 3'd4
    } rx_state_e;

    typedef enum logic [1:0] {
        MD_SHIFT = 2'b00,
        MD_U8VAR = 2'b01,
        MD_U9FIX = 2'b10,
        MD_U9VAR = 2'b11
    } rx_mode_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd_i,
    output logic rx_s_o,
    output logic rx_fall_o
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= rxd_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rx_s_o    = sync_q;
    assign rx_fall_o = prev_q & ~sync_q;

endmodule

// File: rtl/srx_fix_tick.sv
module srx_fix_tick #(
    parameter int SLOW_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dbl_i,
    output logic tick_o
);
    localparam int DW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
    localparam logic [DW-1:0] LIM_SLOW = DW'(SLOW_DIV - 1);
    localparam logic [DW-1:0] LIM_FAST = DW'(SLOW_DIV / 2 - 1);

    logic [DW-1:0] cnt_q;
    logic [DW-1:0] lim;

    assign lim    = dbl_i ? LIM_FAST : LIM_SLOW;
    assign tick_o = (cnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    AST_FIX_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R11

endmodule

// File: rtl/srx_addr_match.sv
module srx_addr_match #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] byte_i,
    input  logic [DATA_W-1:0] own_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic              hit_o
);
    logic [DATA_W-1:0] bcast;
    logic              own_hit;
    logic              bc_hit;

    always_comb begin
        bcast   = own_i | mask_i;
        own_hit = ((byte_i ^ own_i) & mask_i) == '0;
        bc_hit  = (byte_i & bcast) == bcast;
        hit_o   = own_hit | bc_hit;
    end

endmodule

// File: rtl/srx_frame.sv
module srx_frame
    import srx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_s_i,
    input  logic              rx_fall_i,
    input  logic              tick_i,
    input  logic              en_i,
    input  logic              nine_i,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              ninth_o,
    output logic              stop_ok_o
);
    localparam int CW  = $clog2(OVS);
    localparam int BW  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] MID   = CW'(OVS / 2 + 1);
    localparam logic [CW-1:0] SMP0  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] SMP1  = CW'(OVS / 2);
    localparam logic [BW-1:0] LASTB = BW'(DATA_W - 1);

    rx_state_e         state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic [BW-1:0]     bitn_q;
    logic [DATA_W-1:0] sh_q;
    logic              s0_q, s1_q;
    logic              nin_q, stop_q, done_q;
    logic              mid, vote;

    assign mid  = tick_i && (cnt_q == MID);
    assign vote = maj3(s0_q, s1_q, rx_s_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (en_i && rx_fall_i) state_d = S_START;
            S_START: if (mid) state_d = vote ? S_IDLE : S_DATA;
            S_DATA:  if (mid && bitn_q == LASTB) state_d = nine_i ? S_NINTH : S_STOP;
            S_NINTH: if (mid) state_d = S_STOP;
            S_STOP:  if (mid) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bitn_q <= '0;
            sh_q   <= '0;
            s0_q   <= 1'b1;
            s1_q   <= 1'b1;
            nin_q  <= 1'b0;
            stop_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == S_IDLE) begin
                cnt_q <= '0;
            end else if (tick_i) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == SMP0) s0_q <= rx_s_i;
                if (cnt_q == SMP1) s1_q <= rx_s_i;
            end
            if (mid) begin
                unique case (state_q)
                    S_START: bitn_q <= '0;
                    S_DATA: begin
                        sh_q   <= {vote, sh_q[DATA_W-1:1]};
                        bitn_q <= bitn_q + 1'b1;
                    end
                    S_NINTH: nin_q <= vote;
                    S_STOP: begin
                        stop_q <= vote;
                        done_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign done_o    = done_q;
    assign data_o    = sh_q;
    assign ninth_o   = nin_q;
    assign stop_ok_o = stop_q;

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !en_i) |=> (state_q == S_IDLE)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R5
    AST_GLITCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_START && mid && vote) |=> (state_q == S_IDLE)); // R12

endmodule

// File: rtl/srx_port.sv
module srx_port
    import srx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int OVS      = 16,
    parameter int SLOW_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              var_tick,
    input  logic              fix_dbl,
    input  logic              sel_fe,
    input  logic [DATA_W-1:0] own_addr,
    input  logic [DATA_W-1:0] addr_mask,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [DATA_W-1:0] rx_buf
);
    logic              rx_s, rx_fall, fix_tick, tick;
    logic              rx_done, rx_ninth, rx_stop_ok, addr_hit;
    logic [DATA_W-1:0] rx_data;
    logic              sm_a_q, fe_q, sm_b_q, flt_q, ren_q, tb8_q, rb8_q, ti_q, ri_q;
    logic [DATA_W-1:0] buf_q;
    rx_mode_e          mode;
    logic              nine, rx_en, accept;

    assign mode  = rx_mode_e'({sm_a_q, sm_b_q});
    assign nine  = (mode == MD_U9FIX) || (mode == MD_U9VAR);
    assign rx_en = ren_q && (mode != MD_SHIFT);
    assign tick  = (mode == MD_U9FIX) ? fix_tick : var_tick;

    srx_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd_i     (rxd),
        .rx_s_o    (rx_s),
        .rx_fall_o (rx_fall)
    );

    srx_fix_tick #(.SLOW_DIV(SLOW_DIV)) u_fix (
        .clk    (clk),
        .rst_n  (rst_n),
        .dbl_i  (fix_dbl),
        .tick_o (fix_tick)
    );

    srx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_s_i    (rx_s),
        .rx_fall_i (rx_fall),
        .tick_i    (tick),
        .en_i      (rx_en),
        .nine_i    (nine),
        .done_o    (rx_done),
        .data_o    (rx_data),
        .ninth_o   (rx_ninth),
        .stop_ok_o (rx_stop_ok)
    );

    srx_addr_match #(.DATA_W(DATA_W)) u_match (
        .byte_i (rx_data),
        .own_i  (own_addr),
        .mask_i (addr_mask),
        .hit_o  (addr_hit)
    );

    always_comb begin
        if (!flt_q)    accept = 1'b1;
        else if (nine) accept = rx_ninth && addr_hit;
        else           accept = rx_stop_ok && addr_hit;
    end

    // register: CPU write first, receiver events override
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sm_a_q <= 1'b0;
            fe_q   <= 1'b0;
            sm_b_q <= 1'b0;
            flt_q  <= 1'b0;
            ren_q  <= 1'b0;
            tb8_q  <= 1'b0;
            rb8_q  <= 1'b0;
            ti_q   <= 1'b0;
            ri_q   <= 1'b0;
            buf_q  <= '0;
        end else begin
            if (reg_wr) begin
                if (sel_fe) fe_q   <= reg_wdata[7];
                else        sm_a_q <= reg_wdata[7];
                sm_b_q <= reg_wdata[6];
                flt_q  <= reg_wdata[5];
                ren_q  <= reg_wdata[4];
                tb8_q  <= reg_wdata[3];
                rb8_q  <= reg_wdata[2];
                ti_q   <= reg_wdata[1];
                ri_q   <= reg_wdata[0];
            end
            if (rx_done) begin
                if (!rx_stop_ok) fe_q <= 1'b1;
                if (accept) begin
                    ri_q  <= 1'b1;
                    buf_q <= rx_data;
                    rb8_q <= nine ? rx_ninth : rx_stop_ok;
                end
            end
        end
    end

    assign reg_rdata = {(sel_fe ? fe_q : sm_a_q), sm_b_q, flt_q, ren_q,
                        tb8_q, rb8_q, ti_q, ri_q};
    assign rx_buf    = buf_q;

    AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fe_q) |-> $past(reg_wr && sel_fe)); // R3
    AST_FE_ON_BAD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_stop_ok) |=> fe_q); // R3
    AST_RI_CPU_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ri_q) |-> $past(reg_wr)); // R10
    AST_FILTER_NINE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !reg_wr && flt_q && nine && !rx_ninth && !ri_q) |=> !ri_q); // R7
    AST_FILTER_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !reg_wr && flt_q && !nine && !rx_stop_ok && !ri_q) |=> !ri_q); // R8
    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |=> $stable(buf_q)); // R10

endmodule

// File: tb/srx_port_tb.sv
module srx_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       var_tick = 1'b0;
    logic       fix_dbl = 1'b0;
    logic       sel_fe = 1'b0;
    logic [7:0] own_addr = 8'h40;
    logic [7:0] addr_mask = 8'hF0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] rx_buf;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    localparam int BIT_V = 32;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) var_tick <= 1'b0;
        else        var_tick <= ~var_tick;
    end

    srx_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd       (rxd),
        .var_tick  (var_tick),
        .fix_dbl   (fix_dbl),
        .sel_fe    (sel_fe),
        .own_addr  (own_addr),
        .addr_mask (addr_mask),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rx_buf    (rx_buf)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input logic [7:0] v);
        @(negedge clk);
        sel_fe    = sel;
        reg_wr    = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr    = 1'b0;
        sel_fe    = 1'b0;
    endtask

    task automatic rd(input bit sel, output logic [7:0] v);
        @(negedge clk);
        sel_fe = sel;
        #1 v = reg_rdata;
        sel_fe = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input bit has9, input bit n9,
                        input bit stp, input int bitclk);
        @(negedge clk);
        rxd = 1'b0;
        repeat (bitclk) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (bitclk) @(negedge clk);
        end
        if (has9) begin
            rxd = n9;
            repeat (bitclk) @(negedge clk);
        end
        rxd = stp;
        repeat (bitclk) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * bitclk) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(1'b0, v); chk("R1 reg sel0", v, 8'h00);
        rd(1'b1, v); chk("R1 reg sel1", v, 8'h00);
        chk("R1 buffer", rx_buf, 8'h00);
    endtask

    task automatic t_basic8;
        logic [7:0] v;
        wr(1'b0, 8'h50);
        send(8'hA5, 1'b0, 1'b0, 1'b1, BIT_V);
        rd(1'b0, v); chk("R5 RI and RB8=stop", v, 8'h55);
        chk("R5 R12 buffer", rx_buf, 8'hA5);
        rd(1'b1, v); chk("R3 no FE on good stop", v[7], 1'b0);
    endtask

    task automatic t_disabled;
        logic [7:0] v;
        wr(1'b0, 8'h40);
        send(8'h3C, 1'b0, 1'b0, 1'b1, BIT_V);
        rd(1'b0, v); chk("R4 REN=0 no RI", v, 8'h40);
        chk("R4 REN=0 buffer kept", rx_buf, 8'hA5);
        wr(1'b0, 8'h10);
        send(8'h77, 1'b0, 1'b0, 1'b1, BIT_V);
        rd(1'b0, v); chk("R4 mode00 no RI", v, 8'h10);
        chk("R4 mode00 buffer kept", rx_buf, 8'hA5);
    endtask

    task automatic t_glitch;
        logic [7:0] v;
        wr(1'b0, 8'h50);
        @(negedge clk);
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (64) @(negedge clk);
        rd(1'b0, v); chk("R12 glitch no RI", v, 8'h50);
        send(8'h96, 1'b0, 1'b0, 1'b1, BIT_V);
        chk("R12 frame after glitch", rx_buf, 8'h96);
    endtask

    task automatic t_frame_err;
        logic [7:0] v;
        wr(1'b0, 8'h50);
        send(8'h11, 1'b0, 1'b0, 1'b0, BIT_V);
        rd(1'b0, v); chk("R2 sel0 shows mode bit", v, 8'h51);
        rd(1'b1, v); chk("R3 FE set on bad stop", v, 8'hD1);
        wr(1'b0, 8'h50);
        send(8'h22, 1'b0, 1'b0, 1'b1, BIT_V);
        rd(1'b1, v); chk("R3 FE sticky over good frame", v, 8'hD5);
        wr(1'b1, 8'h50);
        rd(1'b1, v); chk("R3 FE cleared by write", v, 8'h50);
        wr(1'b1, 8'hD0);
        rd(1'b0, v); chk("R2 FE write keeps mode bit", v, 8'h50);
        rd(1'b1, v); chk("R2 FE written via bit7", v, 8'hD0);
        wr(1'b1, 8'h50);
    endtask

    task automatic t_nine;
        logic [7:0] v;
        wr(1'b0, 8'hD0);
        send(8'h5A, 1'b1, 1'b1, 1'b1, BIT_V);
        rd(1'b0, v); chk("R6 ninth=1 in RB8", v, 8'hD5);
        chk("R6 buffer", rx_buf, 8'h5A);
        wr(1'b0, 8'hD0);
        send(8'h5B, 1'b1, 1'b0, 1'b1, BIT_V);
        rd(1'b0, v); chk("R6 ninth=0 in RB8", v, 8'hD1);
        chk("R6 buffer 2", rx_buf, 8'h5B);
    endtask

    task automatic t_filter9;
        logic [7:0] v;
        wr(1'b0, 8'hF0);
        send(8'h47, 1'b1, 1'b1, 1'b1, BIT_V);
        rd(1'b0, v); chk("R7 R9 own hit", v, 8'hF5);
        chk("R9 own hit buffer", rx_buf, 8'h47);
        wr(1'b0, 8'hF0);
        send(8'h4B, 1'b1, 1'b0, 1'b1, BIT_V);
        rd(1'b0, v); chk("R7 ninth=0 rejected", v, 8'hF0);
        chk("R10 buffer kept on reject", rx_buf, 8'h47);
        send(8'h23, 1'b1, 1'b1, 1'b1, BIT_V);
        rd(1'b0, v); chk("R9 miss rejected", v, 8'hF0);
        send(8'hF5, 1'b1, 1'b1, 1'b1, BIT_V);
        rd(1'b0, v); chk("R9 broadcast hit", v, 8'hF5);
        chk("R9 broadcast buffer", rx_buf, 8'hF5);
    endtask

    task automatic t_filter8;
        logic [7:0] v;
        wr(1'b0, 8'h70);
        send(8'h4C, 1'b0, 1'b0, 1'b1, BIT_V);
        rd(1'b0, v); chk("R8 good stop accepted", v, 8'h75);
        chk("R8 buffer", rx_buf, 8'h4C);
        wr(1'b0, 8'h70);
        send(8'h4D, 1'b0, 1'b0, 1'b0, BIT_V);
        rd(1'b0, v); chk("R8 bad stop rejected", v, 8'h70);
        chk("R8 buffer kept", rx_buf, 8'h4C);
        rd(1'b1, v); chk("R3 FE despite discard", v, 8'hF0);
        wr(1'b1, 8'h70);
    endtask

    task automatic t_fixed;
        logic [7:0] v;
        wr(1'b0, 8'h90);
        fix_dbl = 1'b1;
        send(8'h3E, 1'b1, 1'b1, 1'b1, 32);
        rd(1'b0, v); chk("R11 fixed fast", v, 8'h95);
        chk("R11 fixed fast buffer", rx_buf, 8'h3E);
        wr(1'b0, 8'h90);
        fix_dbl = 1'b0;
        send(8'hC1, 1'b1, 1'b0, 1'b1, 64);
        rd(1'b0, v); chk("R11 fixed slow", v, 8'h91);
        chk("R11 fixed slow buffer", rx_buf, 8'hC1);
    endtask

    task automatic t_cpu_bits;
        logic [7:0] v;
        wr(1'b0, 8'h4A);
        rd(1'b0, v); chk("R10 TB8 TI held", v, 8'h4A);
        wr(1'b0, 8'h40);
        rd(1'b0, v); chk("R10 TI cleared by write", v, 8'h40);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset;
        t_basic8;
        t_disabled;
        t_glitch;
        t_frame_err;
        t_nine;
        t_filter9;
        t_filter8;
        t_fixed;
        t_cpu_bits;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule